// File: doc/BRIEF.md
# Adaptive High-Power Sequence Filter

This block sits in each core after the power estimator. Every time a code sequence completes, the block receives it with a 7-bit average power value, a 64-bit sequence identifier and the addresses of up to five basic blocks that make up the sequence. It forwards only the sequences that are interesting for further power analysis and drops the rest. A sequence is interesting when its power lies in a band just below the highest power seen since reset. The width of that band is a programmable capture ratio, so the pass level adapts on its own as higher-power sequences appear.

The filter keeps three registers. The capture ratio is written by the user. The running peak and its derived pass level are internal and start at zero. A programmable watch address, once armed, forces any sequence that contains that basic block to be forwarded, whatever its power. Forwarded sequences appear on a registered output one cycle later, with their identifier and power passed through unchanged.

Top module: `hp_seq_filter`

## Requirements
- R1: After reset, fwd_valid is 0, the peak and pass level are 0, the capture ratio is 0 and the watch is disarmed, so the first sequence after reset is forwarded even at power 0.
- R2: A sequence presented with seq_valid high in one cycle that is forwarded raises fwd_valid for exactly the next cycle, with fwd_id and fwd_power equal to the presented seq_id and seq_power.
- R3: The pass level is peak − ((peak × C) >> 8), where C is the 8-bit capture ratio in units of 1/256. A sequence whose power is at or above the pass level is forwarded, and one below it is dropped (for example, peak 100 and C 26 give a level of 90).
- R4: A sequence whose power is strictly above the current peak is forwarded and becomes the new peak, and the pass level is recomputed from it. A power equal to or below the peak leaves the peak unchanged.
- R5: A capture-ratio write (ratio_we high) recomputes the pass level from the current peak. A sequence presented in the same cycle as the write is judged against the old pass level.
- R6: When the watch is armed, a sequence is forwarded regardless of its power if any of its first seq_blk_cnt block addresses equals the watch address. Block slot i occupies seq_blk_addr bits [i*32 +: 32].
- R7: Block slots at index seq_blk_cnt and above are ignored for the watch comparison.
- R8: A watch write with watch_arm low disarms the watch, after which no sequence is forwarded because of a watched address.
- R9: While seq_valid is low, nothing is forwarded and the peak does not change, whatever the values on seq_power.
- R10: With C = 0 the pass level equals the peak. With C = 255 and a peak of 127 the pass level is 1.

Note that R1 refers only to 0 as the reset value of each register; no other value is implied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_we | input | 1 | Write strobe for the capture ratio |
| ratio_wdata | input | 8 | New capture ratio, units of 1/256 |
| watch_we | input | 1 | Write strobe for the watch register |
| watch_arm | input | 1 | 1 arms the watch with watch_addr, 0 disarms it |
| watch_addr | input | 32 | Basic-block address to watch |
| seq_valid | input | 1 | A completed sequence is presented this cycle |
| seq_id | input | 64 | Sequence identifier |
| seq_power | input | 7 | Average power of the sequence |
| seq_blk_cnt | input | 3 | Number of valid block slots, 1 to 5 |
| seq_blk_addr | input | 160 | Five 32-bit block addresses, slot 0 in the low bits |
| fwd_valid | output | 1 | Forwarded sequence valid |
| fwd_id | output | 64 | Identifier of the forwarded sequence |
| fwd_power | output | 7 | Power of the forwarded sequence |

## Verification
A corrupted peak or pass level cannot be read directly. It shows up as a wrong keep or drop decision on fwd_valid one cycle after the next sequence whose power lies between the right and the wrong level. For that reason the stimulus places powers exactly at the pass level and one below it, right after each change of the peak or the ratio. A wrong watch state shows on the first sequence that carries the watched address, either in range or beyond the block count, at a power that would otherwise be dropped.

// File: rtl/hp_filt_pkg.sv
package hp_filt_pkg;

    localparam int unsigned DEF_PWR_W   = 7;
    localparam int unsigned DEF_RATIO_W = 8;
    localparam int unsigned DEF_ID_W    = 64;
    localparam int unsigned DEF_ADDR_W  = 32;
    localparam int unsigned DEF_NBLK    = 5;

    // Why a sequence leaves the filter (or does not)
    typedef enum logic [1:0] {
        CAUSE_DROP  = 2'd0,
        CAUSE_WATCH = 2'd1,
        CAUSE_PEAK  = 2'd2,
        CAUSE_BAND  = 2'd3
    } fwd_cause_e;

    // Pass level: peak minus the capture-ratio share of the peak
    function automatic logic [31:0] band_floor(input logic [31:0] peak,
                                               input logic [31:0] ratio,
                                               input int unsigned rbits);
        logic [31:0] share;
        share = (peak * ratio) >> rbits;
        return peak - share;
    endfunction

endpackage

// File: rtl/hp_watch_match.sv
module hp_watch_match #(
    parameter int unsigned ADDR_W = hp_filt_pkg::DEF_ADDR_W,
    parameter int unsigned NBLK   = hp_filt_pkg::DEF_NBLK,
    parameter int unsigned CNT_W  = $clog2(NBLK + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   watch_we,
    input  logic                   watch_arm,
    input  logic [ADDR_W-1:0]      watch_addr,
    input  logic [CNT_W-1:0]       blk_cnt,
    input  logic [NBLK*ADDR_W-1:0] blk_addr,
    output logic                   hit
);

    logic              armed_q;
    logic [ADDR_W-1:0] addr_q;
    logic [NBLK-1:0]   slot_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            addr_q  <= '0;
        end else if (watch_we) begin
            armed_q <= watch_arm;
            addr_q  <= watch_addr;
        end
    end

    for (genvar i = 0; i < NBLK; i++) begin : g_slot
        assign slot_hit[i] = (CNT_W'(i) < blk_cnt) &&
                             (blk_addr[i*ADDR_W +: ADDR_W] == addr_q);
    end

    assign hit = armed_q && (|slot_hit);

    // R8: a disarm write leaves no hit in the following cycle
    assert_disarm_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (watch_we && !watch_arm) |=> !hit);

endmodule

// File: rtl/hp_peak_track.sv
module hp_peak_track #(
    parameter int unsigned PWR_W   = hp_filt_pkg::DEF_PWR_W,
    parameter int unsigned RATIO_W = hp_filt_pkg::DEF_RATIO_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ratio_we,
    input  logic [RATIO_W-1:0] ratio_wdata,
    input  logic               seq_valid,
    input  logic [PWR_W-1:0]   seq_power,
    output logic [PWR_W-1:0]   peak,
    output logic [PWR_W-1:0]   pass_level,
    output logic               new_peak
);
    import hp_filt_pkg::*;

    logic [RATIO_W-1:0] ratio_q;
    logic [PWR_W-1:0]   peak_q;
    logic [PWR_W-1:0]   level_q;
    logic [PWR_W-1:0]   peak_n;
    logic [RATIO_W-1:0] ratio_n;
    logic [PWR_W-1:0]   level_n;
    logic               run_q;

    assign new_peak = seq_valid && (seq_power > peak_q);
    assign peak_n   = new_peak ? seq_power : peak_q;
    assign ratio_n  = ratio_we ? ratio_wdata : ratio_q;
    assign level_n  = PWR_W'(band_floor(32'(peak_n), 32'(ratio_n), RATIO_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_q <= '0;
            peak_q  <= '0;
            level_q <= '0;
            run_q   <= 1'b0;
        end else begin
            run_q   <= 1'b1;
            ratio_q <= ratio_n;
            peak_q  <= peak_n;
            if (new_peak || ratio_we) begin
                level_q <= level_n;
            end
        end
    end

    assign peak       = peak_q;
    assign pass_level = level_q;

    // R4: the peak never falls while running
    assert_peak_monotonic_R4: assert property (@(posedge clk) disable iff (rst || !run_q)
        peak_q >= $past(peak_q));

    // R4: a higher power becomes the peak on the next cycle
    assert_peak_capture_R4: assert property (@(posedge clk) disable iff (rst)
        new_peak |=> (peak_q == $past(seq_power)));

    // R9: without a valid sequence the peak holds
    assert_idle_holds_peak_R9: assert property (@(posedge clk) disable iff (rst)
        !seq_valid |=> $stable(peak_q));

    // R3: the pass level never exceeds the peak
    assert_level_below_peak_R3: assert property (@(posedge clk) disable iff (rst)
        level_q <= peak_q);

    // R10: a zero ratio puts the pass level at the peak
    assert_zero_ratio_R10: assert property (@(posedge clk) disable iff (rst)
        (ratio_q == '0) |-> (level_q == peak_q));

endmodule

// File: rtl/hp_seq_filter.sv
module hp_seq_filter #(
    parameter int unsigned PWR_W   = hp_filt_pkg::DEF_PWR_W,
    parameter int unsigned RATIO_W = hp_filt_pkg::DEF_RATIO_W,
    parameter int unsigned ID_W    = hp_filt_pkg::DEF_ID_W,
    parameter int unsigned ADDR_W  = hp_filt_pkg::DEF_ADDR_W,
    parameter int unsigned NBLK    = hp_filt_pkg::DEF_NBLK,
    parameter int unsigned CNT_W   = $clog2(NBLK + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ratio_we,
    input  logic [RATIO_W-1:0]     ratio_wdata,
    input  logic                   watch_we,
    input  logic                   watch_arm,
    input  logic [ADDR_W-1:0]      watch_addr,
    input  logic                   seq_valid,
    input  logic [ID_W-1:0]        seq_id,
    input  logic [PWR_W-1:0]       seq_power,
    input  logic [CNT_W-1:0]       seq_blk_cnt,
    input  logic [NBLK*ADDR_W-1:0] seq_blk_addr,
    output logic                   fwd_valid,
    output logic [ID_W-1:0]        fwd_id,
    output logic [PWR_W-1:0]       fwd_power
);
    import hp_filt_pkg::*;

    logic             watch_hit;
    logic [PWR_W-1:0] peak;
    logic [PWR_W-1:0] pass_level;
    logic             new_peak;
    fwd_cause_e       cause;

    logic             fv_q;
    logic [ID_W-1:0]  fid_q;
    logic [PWR_W-1:0] fpw_q;

    hp_watch_match #(
        .ADDR_W (ADDR_W),
        .NBLK   (NBLK),
        .CNT_W  (CNT_W)
    ) u_watch (
        .clk        (clk),
        .rst        (rst),
        .watch_we   (watch_we),
        .watch_arm  (watch_arm),
        .watch_addr (watch_addr),
        .blk_cnt    (seq_blk_cnt),
        .blk_addr   (seq_blk_addr),
        .hit        (watch_hit)
    );

    hp_peak_track #(
        .PWR_W   (PWR_W),
        .RATIO_W (RATIO_W)
    ) u_peak (
        .clk         (clk),
        .rst         (rst),
        .ratio_we    (ratio_we),
        .ratio_wdata (ratio_wdata),
        .seq_valid   (seq_valid),
        .seq_power   (seq_power),
        .peak        (peak),
        .pass_level  (pass_level),
        .new_peak    (new_peak)
    );

    always_comb begin
        cause = CAUSE_DROP;
        if (seq_valid) begin
            if (watch_hit) begin
                cause = CAUSE_WATCH;
            end else if (new_peak) begin
                cause = CAUSE_PEAK;
            end else if (seq_power >= pass_level) begin
                cause = CAUSE_BAND;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fv_q  <= 1'b0;
            fid_q <= '0;
            fpw_q <= '0;
        end else begin
            fv_q <= (cause != CAUSE_DROP);
            if (cause != CAUSE_DROP) begin
                fid_q <= seq_id;
                fpw_q <= seq_power;
            end
        end
    end

    assign fwd_valid = fv_q;
    assign fwd_id    = fid_q;
    assign fwd_power = fpw_q;

    // R2: forwarded data is the sequence presented one cycle earlier
    assert_passthru_R2: assert property (@(posedge clk) disable iff (rst)
        (seq_valid && (cause != CAUSE_DROP)) |=>
            (fwd_valid && fwd_id == $past(seq_id) && fwd_power == $past(seq_power)));

    // R9: no output without a sequence
    assert_idle_no_fwd_R9: assert property (@(posedge clk) disable iff (rst)
        !seq_valid |=> !fwd_valid);

    // R4: a new peak is always forwarded
    assert_peak_forwarded_R4: assert property (@(posedge clk) disable iff (rst)
        (seq_valid && seq_power > peak) |=> fwd_valid);

    // R6: a watched block is always forwarded
    assert_watch_forwarded_R6: assert property (@(posedge clk) disable iff (rst)
        (seq_valid && watch_hit) |=> fwd_valid);

    // R3: a valid sequence below the level with no watch hit is dropped
    assert_below_dropped_R3: assert property (@(posedge clk) disable iff (rst)
        (seq_valid && !watch_hit && seq_power < pass_level) |=> !fwd_valid);

endmodule

// File: tb/hp_seq_filter_tb.sv
module hp_seq_filter_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ratio_we = 1'b0;
    logic [7:0]   ratio_wdata = '0;
    logic         watch_we = 1'b0;
    logic         watch_arm = 1'b0;
    logic [31:0]  watch_addr = '0;
    logic         seq_valid = 1'b0;
    logic [63:0]  seq_id = '0;
    logic [6:0]   seq_power = '0;
    logic [2:0]   seq_blk_cnt = 3'd5;
    logic [159:0] seq_blk_addr = '0;
    logic         fwd_valid;
    logic [63:0]  fwd_id;
    logic [6:0]   fwd_power;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int seq_no = 0;

    localparam logic [31:0] WADDR = 32'h1000_2000;

    // Table: {power[6:0], expected forward} with capture ratio 26 from reset
    localparam int NVEC = 11;
    localparam logic [7:0] VEC [NVEC] = '{
        {7'd50,  1'b1},   // first, new peak; level 45
        {7'd45,  1'b1},   // at level
        {7'd44,  1'b0},   // one below
        {7'd100, 1'b1},   // new peak; level 90
        {7'd90,  1'b1},
        {7'd89,  1'b0},
        {7'd100, 1'b1},   // equal to peak
        {7'd0,   1'b0},
        {7'd127, 1'b1},   // new peak; level 115
        {7'd115, 1'b1},
        {7'd114, 1'b0}
    };

    hp_seq_filter u_dut (
        .clk          (clk),
        .rst          (rst),
        .ratio_we     (ratio_we),
        .ratio_wdata  (ratio_wdata),
        .watch_we     (watch_we),
        .watch_arm    (watch_arm),
        .watch_addr   (watch_addr),
        .seq_valid    (seq_valid),
        .seq_id       (seq_id),
        .seq_power    (seq_power),
        .seq_blk_cnt  (seq_blk_cnt),
        .seq_blk_addr (seq_blk_addr),
        .fwd_valid    (fwd_valid),
        .fwd_id       (fwd_id),
        .fwd_power    (fwd_power)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        seq_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_ratio(input logic [7:0] r);
        ratio_we = 1'b1;
        ratio_wdata = r;
        @(negedge clk);
        ratio_we = 1'b0;
    endtask

    task automatic write_watch(input logic arm, input logic [31:0] a);
        watch_we = 1'b1;
        watch_arm = arm;
        watch_addr = a;
        @(negedge clk);
        watch_we = 1'b0;
    endtask

    // Present one sequence at a negedge, check the registered result a cycle later,
    // then check the output returns low after the idle cycle.
    task automatic send_seq(input string req, input logic [6:0] p, input logic [2:0] cnt,
                            input logic [159:0] addrs, input logic exp);
        logic [63:0] id;
        seq_no++;
        id = {32'hC0DE_0000, 32'(seq_no)};
        seq_valid = 1'b1;
        seq_power = p;
        seq_id = id;
        seq_blk_cnt = cnt;
        seq_blk_addr = addrs;
        @(negedge clk);
        seq_valid = 1'b0;
        seq_power = 7'd127;
        check_bit(req, fwd_valid, exp);
        if (exp && fwd_valid) begin
            checks++;
            if (fwd_id !== id || fwd_power !== p) begin
                fails++;
                $display("FAIL R2: actual id %h power %0d expected id %h power %0d",
                         fwd_id, fwd_power, id, p);
            end
        end
        @(negedge clk);
        check_bit("R2 single-cycle pulse", fwd_valid, 1'b0);
    endtask

    initial begin
        do_reset();
        // R1: reset state, first sequence at power 0 is forwarded
        check_bit("R1 reset fwd_valid", fwd_valid, 1'b0);
        send_seq("R1 first after reset", 7'd0, 3'd5, '0, 1'b1);

        // R9: idle cycle with a high power must not raise the peak
        do_reset();
        seq_valid = 1'b0;
        seq_power = 7'd90;
        @(negedge clk);
        check_bit("R9 idle no fwd", fwd_valid, 1'b0);
        send_seq("R9 peak unchanged by idle", 7'd50, 3'd5, '0, 1'b1);
        send_seq("R9 peak is 50 not 90", 7'd49, 3'd5, '0, 1'b0);

        // Table walk: R3 and R4 with capture ratio 26
        do_reset();
        write_ratio(8'd26);
        for (int k = 0; k < NVEC; k++) begin
            send_seq("R3/R4 table", VEC[k][7:1], 3'd5, '0, VEC[k][0]);
        end

        // R5: ratio write in the same cycle as a sequence uses the old level (115)
        ratio_we = 1'b1;
        ratio_wdata = 8'd0;
        send_seq("R5 same-cycle old level", 7'd120, 3'd5, '0, 1'b1);
        ratio_we = 1'b0;
        send_seq("R5 new level applied R10 C=0", 7'd126, 3'd5, '0, 1'b0);
        send_seq("R10 C=0 at peak", 7'd127, 3'd5, '0, 1'b1);

        // R10: ratio 255 with peak 127 gives level 1
        write_ratio(8'd255);
        send_seq("R10 C=255 at level", 7'd1, 3'd5, '0, 1'b1);
        send_seq("R10 C=255 below level", 7'd0, 3'd5, '0, 1'b0);

        // R6/R7/R8: watch address with level back at the peak
        write_ratio(8'd0);
        send_seq("R6 unarmed low power", 7'd3, 3'd5, {WADDR, 128'h0}, 1'b0);
        write_watch(1'b1, WADDR);
        send_seq("R6 hit in slot 4", 7'd3, 3'd5, {WADDR, 128'h0}, 1'b1);
        send_seq("R6 hit in slot 2", 7'd3, 3'd3, {64'h0, WADDR, 64'h0}, 1'b1);
        send_seq("R7 slot 3 beyond count", 7'd3, 3'd3, {32'h0, WADDR, 96'h0}, 1'b0);
        send_seq("R7 slot 0 count 1", 7'd3, 3'd1, {128'h0, WADDR}, 1'b1);
        write_watch(1'b0, WADDR);
        send_seq("R8 disarmed", 7'd3, 3'd1, {128'h0, WADDR}, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule